// File: doc/BRIEF.md
# Software-Fault Watchdog with Bit-6 Timeout

This block watches for a stalled or runaway program on a small microcontroller. Software writes one control word. Bit 7 of that word arms the watchdog, and bits 6:0 load a 7-bit down-counter. A fixed prescaler steps the counter down once every `PRESCALE` CPU clock cycles. The timeout does not wait for the counter to reach zero. It fires when bit 6 of the counter drops, which is the step from 40h to 3Fh. Loading any value from 40h to 7Fh therefore gives one of 64 timeout lengths. Software must rewrite the counter before bit 6 clears.

Once armed, the block drives an active-low reset pulse of `PULSE_CYCLES` cycles in three cases: the counter times out, a halt instruction is signalled, or a write leaves bit 6 clear. Software cannot disarm it; only a system reset does. A board-level option input can keep the watchdog permanently active. A status flag records that the watchdog caused the last reset. The flag and the pulse generator sit on the power-on reset, so the system reset that the pulse itself triggers does not wipe them. Every pin is a plain control or status signal, so no stream handshake is used.

Top module: `swfault_watchdog`

## Requirements
- R1: After power-on reset (`por_n` and `rst_n` low) the counter reads 7Fh, `rst_out_n` is 1 and `wdg_flag` is 0.
- R2: A write loads bits 6:0 into the counter and clears the prescaler. The counter then steps down by one exactly `PRESCALE` cycles after the write edge, and again every `PRESCALE` cycles after that.
- R3: Writing 1 in bit 7 arms the watchdog. Writing 0 there has no effect. Only `rst_n` disarms it.
- R4: While armed, after a write of value V (with bit 6 set) at clock edge E, `rst_out_n` goes low at edge E + (V - 3Fh) * `PRESCALE`, the edge where the counter steps from 40h to 3Fh.
- R5: Each reset pulse holds `rst_out_n` low for exactly `PULSE_CYCLES` cycles.
- R6: A one-cycle `halt_strobe` while armed starts a pulse at the same edge. While not armed it is ignored.
- R7: While `hw_force_en` is 1 the watchdog is armed regardless of software, and `rd_data[7]` reads 1.
- R8: `wdg_flag` is set when a pulse starts. It survives `rst_n`. It is cleared by a read strobe, a write, or `por_n`.
- R9: A write whose bit 6 is 0 starts a pulse at that edge if the watchdog is armed or the same write arms it. If the watchdog stays unarmed, the write only loads the counter.
- R10: While not armed, the counter keeps counting and wraps from 00h to 7Fh, and no pulse is produced.
- R11: `rd_data` presents the armed state in bit 7 and the counter in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, active low; clears the flag and the pulse generator |
| rst_n | input | 1 | System reset, active low; clears the counter, prescaler and armed state |
| hw_force_en | input | 1 | Option input that forces the watchdog armed |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Bit 7 arms; bits 6:0 are the counter load value |
| rd_en | input | 1 | Read strobe; clears the status flag |
| rd_data | output | 8 | {armed, counter[6:0]} |
| halt_strobe | input | 1 | One-cycle pulse when a halt instruction executes |
| rst_out_n | output | 1 | Active-low reset pulse to the system reset controller |
| wdg_flag | output | 1 | Last reset came from the watchdog |

## Verification
The assertions assume `hw_force_en` changes only while `rst_n` is low. They also assume `rst_out_n` is not fed straight back into `rst_n` within the same cycle, so the armed state and the counter move only by writes, prescaler steps and resets. The bench holds the option input steady and changes it only inside its system-reset task. It issues the system reset itself, after each pulse has ended, rather than looping the pulse back. Writes, reads and halt strobes each last one cycle and are driven on the falling clock edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef logic [6:0] wdt_count_t;
  localparam wdt_count_t WDT_COUNT_INIT = 7'h7F;
  localparam wdt_count_t WDT_EDGE_VALUE = 7'h40;
  localparam int WDT_ARM_BIT = 7;
  localparam int WDT_T6_BIT  = 6;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clear;
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  wdt_count_t load_val,
  input  logic       tick,
  output wdt_count_t count,
  output logic       edge_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= WDT_COUNT_INIT;
    else if (load) count <= load_val;
    else if (tick) count <= count - 7'd1;
  end

  assign edge_hit = tick && !load && (count == WDT_EDGE_VALUE);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 125
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic busy,
  output logic pulse_n
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) remain <= '0;
    else if (fire && !busy) remain <= CW'(LEN);
    else if (busy) remain <= remain - 1'b1;
  end

  assign busy    = (remain != '0);
  assign pulse_n = !busy;
endmodule

// File: rtl/swfault_watchdog.sv
module swfault_watchdog
  import wdt_pkg::*;
#(
  parameter int PRESCALE     = 12288,
  parameter int PULSE_CYCLES = 125
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       hw_force_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       halt_strobe,
  output logic       rst_out_n,
  output logic       wdg_flag
);
  logic       armed_q;
  logic       armed;
  logic       tick;
  logic       edge_hit;
  logic       busy;
  logic       fire;
  logic       wr_fire;
  wdt_count_t count;

  assign armed = armed_q | hw_force_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (wr_en && wr_data[WDT_ARM_BIT]) armed_q <= 1'b1;
  end

  wdt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wr_en),
    .tick  (tick)
  );

  wdt_downcounter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en),
    .load_val (wr_data[6:0]),
    .tick     (tick),
    .count    (count),
    .edge_hit (edge_hit)
  );

  assign wr_fire = wr_en && !wr_data[WDT_T6_BIT] && (armed || wr_data[WDT_ARM_BIT]);
  assign fire = rst_n && !busy &&
                ((armed && (edge_hit || halt_strobe)) || wr_fire);

  wdt_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .por_n   (por_n),
    .fire    (fire),
    .busy    (busy),
    .pulse_n (rst_out_n)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wdg_flag <= 1'b0;
    else if (fire) wdg_flag <= 1'b1;
    else if (rd_en || wr_en) wdg_flag <= 1'b0;
  end

  assign rd_data = {armed, count};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       halt_strobe,
  input logic       rst_out_n,
  input logic       wdg_flag
);
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wr_en |=> rd_data[6:0] == $past(wr_data[6:0])); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !wr_en |=> (rd_data[6:0] == $past(rd_data[6:0]) ||
                rd_data[6:0] == $past(rd_data[6:0]) - 7'd1)); // R2

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rd_data[7] |=> rd_data[7]); // R3

  AST_HALT_FIRES: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_data[7] && halt_strobe && rst_out_n) |=> !rst_out_n); // R6

  AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(rst_out_n) |-> wdg_flag); // R8

  AST_T6_WRITE_FIRES: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wr_en && !wr_data[6] && (wr_data[7] || rd_data[7]) && rst_out_n) |=> !rst_out_n); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rst_out_n && !rd_data[7] && !wr_en) |=> rst_out_n); // R10
endmodule

bind swfault_watchdog wdt_checker u_wdt_checker (
  .clk         (clk),
  .por_n       (por_n),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .halt_strobe (halt_strobe),
  .rst_out_n   (rst_out_n),
  .wdg_flag    (wdg_flag)
);

// File: tb/swfault_watchdog_bench.sv
`timescale 1ns/1ps
module swfault_watchdog_bench;
  localparam int P   = 16;
  localparam int LEN = 8;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_force_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       halt_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       rst_out_n;
  logic       wdg_flag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  swfault_watchdog #(.PRESCALE(P), .PULSE_CYCLES(LEN)) u_swfault_watchdog (
    .clk (clk), .por_n (por_n), .rst_n (rst_n), .hw_force_en (hw_force_en),
    .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
    .halt_strobe (halt_strobe), .rst_out_n (rst_out_n), .wdg_flag (wdg_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0; hw_force_en = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sys_reset(input logic hw);
    @(negedge clk); rst_n = 1'b0; hw_force_en = hw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic halt_pulse();
    halt_strobe = 1'b1;
    @(negedge clk);
    halt_strobe = 1'b0;
  endtask

  task automatic wait_pulse_end();
    while (!rst_out_n) @(negedge clk);
  endtask

  task automatic t_reset();
    power_on();
    chk("R1 counter", rd_data, 8'h7F);
    chk("R11 read format", rd_data[7], 0);
    chk("R1 rst_out_n", rst_out_n, 1);
    chk("R1 flag", wdg_flag, 0);
  endtask

  task automatic t_prescale();
    sys_reset(1'b0);
    wr(8'h50);
    repeat (P - 1) @(negedge clk);
    chk("R2 before step", rd_data[6:0], 7'h50);
    @(negedge clk);
    chk("R2 first step", rd_data[6:0], 7'h4F);
    repeat (P) @(negedge clk);
    chk("R2 second step", rd_data[6:0], 7'h4E);
    repeat (5) @(negedge clk);
    wr(8'h50);
    repeat (P - 1) @(negedge clk);
    chk("R2 prescaler cleared", rd_data[6:0], 7'h50);
    @(negedge clk);
    chk("R2 step after restart", rd_data[6:0], 7'h4F);
  endtask

  task automatic t_timeout(input logic [6:0] v);
    int n = 0;
    int low = 0;
    sys_reset(1'b0);
    wr({1'b1, v});
    while (rst_out_n && n < 5000) begin
      @(negedge clk); n++;
    end
    chk("R4 cycles to timeout", n, (int'(v) - 63) * P);
    chk("R4 counter after edge", rd_data[6:0], 7'h3F);
    chk("R8 flag set", wdg_flag, 1);
    while (!rst_out_n && low < 1000) begin
      @(negedge clk); low++;
    end
    chk("R5 pulse length", low, LEN);
  endtask

  task automatic t_arm();
    sys_reset(1'b0);
    wr(8'h7F);
    chk("R3 write 0 leaves unarmed", rd_data[7], 0);
    wr(8'hFF);
    chk("R3 write 1 arms", rd_data[7], 1);
    wr(8'h7F);
    chk("R3 write 0 ignored", rd_data[7], 1);
    chk("R3 no pulse", rst_out_n, 1);
    sys_reset(1'b0);
    chk("R3 system reset disarms", rd_data[7], 0);
  endtask

  task automatic t_halt_flag();
    sys_reset(1'b0);
    wr(8'h7F);
    halt_pulse();
    chk("R6 halt ignored while unarmed", rst_out_n, 1);
    wr(8'hFF);
    chk("R8 write clears flag precondition", wdg_flag, 0);
    halt_pulse();
    chk("R6 halt fires", rst_out_n, 0);
    chk("R8 flag on halt", wdg_flag, 1);
    wait_pulse_end();
    sys_reset(1'b0);
    chk("R8 flag survives rst_n", wdg_flag, 1);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R8 read clears flag", wdg_flag, 0);
    wr(8'hFF); halt_pulse(); wait_pulse_end();
    wr(8'hFF);
    chk("R8 write clears flag", wdg_flag, 0);
    halt_pulse(); wait_pulse_end();
    power_on();
    chk("R8 por clears flag", wdg_flag, 0);
  endtask

  task automatic t_hw_force();
    sys_reset(1'b1);
    chk("R7 forced armed", rd_data[7], 1);
    wr(8'h7F);
    chk("R7 still armed", rd_data[7], 1);
    halt_pulse();
    chk("R7 halt fires when forced", rst_out_n, 0);
    wait_pulse_end();
    sys_reset(1'b0);
  endtask

  task automatic t_t6_write();
    sys_reset(1'b0);
    wr(8'hB0);
    chk("R9 arming write with bit6 clear fires", rst_out_n, 0);
    wait_pulse_end();
    sys_reset(1'b0);
    wr(8'h30);
    chk("R9 unarmed write with bit6 clear quiet", rst_out_n, 1);
    chk("R9 counter loaded", rd_data[6:0], 7'h30);
    wr(8'hC5);
    wr(8'h20);
    chk("R9 armed write with bit6 clear fires", rst_out_n, 0);
    wait_pulse_end();
  endtask

  task automatic t_unarmed_wrap();
    int lows = 0;
    sys_reset(1'b0);
    wr(8'h41);
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk);
      if (!rst_out_n) lows++;
    end
    chk("R10 no pulse across 40h->3Fh", lows, 0);
    wr(8'h01);
    repeat (2 * P) @(negedge clk);
    chk("R10 wraps to 7Fh", rd_data[6:0], 7'h7F);
    chk("R10 still quiet", rst_out_n, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale();
    t_timeout(7'h41);
    t_timeout(7'h45);
    t_timeout(7'h7F);
    t_arm();
    t_halt_flag();
    t_hw_force();
    t_t6_write();
    t_unarmed_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule